// File: doc/BRIEF.md
# Warp-Wide Banked Scratchpad with Conflict Replay

This block is an on-chip scratchpad shared by the lanes of one warp. A single request carries, for every lane, a word address, a write word and an enable bit in the lane mask. One read/write flag applies to the whole request. Storage is split across equal banks, and each bank serves one row per cycle. The block works out which lanes land in which bank and issues the request over as many cycles as needed. Lanes that hit the same word in the same bank are handled together, so only distinct words in one bank cost extra cycles.

The request is taken on a rising edge where `req_valid` and `req_ready` are both high. Once taken, `req_ready` stays low until the block has finished the request. `rsp_done` then pulses for one cycle, and the gathered read words appear on `rsp_rdata`. A compile-time choice swaps the plain low-bits bank selection for a folded one that spreads power-of-two strides.

Top module: `banked_scratchpad`

## Requirements
- R1: With the default mapping, the bank of word address A is A[4:0] (A modulo 32) and its row inside the bank is A[8:5]. K is the largest number of distinct addresses among active lanes that share one bank. `rsp_done` is high in the cycle after the (K+1)-th rising edge that follows the accepting edge.
- R2: Unit-stride addresses, any odd stride over 32 lanes, and any one-to-one permutation of the 32 banks all give K=1. Such a request finishes with `rsp_done` two edges after acceptance.
- R3: With the default mapping, strides 2, 4, 8 and 16 give K = 2, 4, 8 and 16 respectively.
- R4: Active lanes that read the same address count as one access, get the same word back, and add no cycles.
- R5: A read returns, for each active lane, the word most recently written at its address. Inactive lanes read back zero. A write request returns zero on every lane, and inactive lanes write nothing.
- R6: When several active lanes of one write request target the same address, the word from the highest-numbered active lane is stored.
- R7: `req_ready` is low from the cycle after acceptance until the cycle in which `rsp_done` is high. `req_valid` asserted while `req_ready` is low has no effect.
- R8: `rsp_done` is high for exactly one cycle per request. `rsp_rdata` holds its value from that cycle until the next request is accepted.
- R9: With HASH=1, the bank is A[4:0] XOR {0, A[8:5]} and the row is still A[8:5]. Stride 16 over 32 lanes then gives K=1 instead of 16.
- R10: After reset, `req_ready` is 1, `rsp_done` is 0 and `rsp_rdata` is all zero.
- R11: A request with an all-zero lane mask gives K=0. It finishes with `rsp_done` one edge after acceptance and returns all-zero data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_mask | input | LANES | Per-lane enable |
| req_addr | input | LANES*AW | Per-lane word address, lane 0 in the low bits |
| req_wdata | input | LANES*DW | Per-lane write word, lane 0 in the low bits |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LANES*DW | Gathered read words, lane 0 in the low bits |

## Verification
The bench uses several address patterns, and each one separates cases the others cannot. Unit stride, an odd stride and a bank permutation must all finish in the minimum time. Strides 2, 4, 8 and 16 must take exactly the predicted number of cycles, which catches a conflict counter that is off by one or saturates. A broadcast read tells lanes that share a word apart from lanes that truly conflict. A shared-address write with a partial mask shows which lane's write lands. A second instance with the folded mapping runs the same patterns; its stride-16 timing shows that the mapping variant is in effect and that stored data still comes back intact.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_LAST  = 2'd2
  } spad_state_e;

endpackage

// File: rtl/spad_bank_map.sv
module spad_bank_map #(
  parameter int LANES  = 32,
  parameter int BANK_W = 5,
  parameter int ROW_W  = 4,
  parameter bit HASH   = 1'b0,
  localparam int AW    = BANK_W + ROW_W
) (
  input  logic [LANES-1:0][AW-1:0]     addr,
  output logic [LANES-1:0][BANK_W-1:0] bank,
  output logic [LANES-1:0][ROW_W-1:0]  row
);

  for (genvar t = 0; t < LANES; t++) begin : g_lane
    logic [BANK_W-1:0] low;
    logic [ROW_W-1:0]  hi;
    assign low    = addr[t][BANK_W-1:0];
    assign hi     = addr[t][AW-1:BANK_W];
    assign row[t] = hi;
    if (HASH) begin : g_fold
      if (ROW_W >= BANK_W) begin : g_wide
        assign bank[t] = low ^ hi[BANK_W-1:0];
      end else begin : g_narrow
        assign bank[t] = low ^ {{(BANK_W-ROW_W){1'b0}}, hi};
      end
    end else begin : g_plain
      assign bank[t] = low;
    end
  end

endmodule

// File: rtl/spad_sched.sv
module spad_sched #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int BANK_W = 5,
  parameter int ROW_W  = 4,
  parameter int DW     = 32
) (
  input  logic [LANES-1:0]             pend,
  input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
  input  logic [LANES-1:0][ROW_W-1:0]  lane_row,
  input  logic [LANES-1:0][DW-1:0]     lane_wd,
  output logic [LANES-1:0]             served,
  output logic [BANKS-1:0]             bank_en,
  output logic [BANKS-1:0][ROW_W-1:0]  bank_row,
  output logic [BANKS-1:0][DW-1:0]     bank_wd
);

  // Per bank: the lowest pending lane picks the row; every pending lane
  // on that row rides along. Scanning upward leaves the highest lane's
  // word as the one written.
  always_comb begin
    served   = '0;
    bank_en  = '0;
    bank_row = '0;
    bank_wd  = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int t = 0; t < LANES; t++) begin
        if (pend[t] && lane_bank[t] == BANK_W'(b) && !bank_en[b]) begin
          bank_en[b]  = 1'b1;
          bank_row[b] = lane_row[t];
        end
      end
      for (int t = 0; t < LANES; t++) begin
        if (bank_en[b] && pend[t] && lane_bank[t] == BANK_W'(b) &&
            lane_row[t] == bank_row[b]) begin
          served[t]  = 1'b1;
          bank_wd[b] = lane_wd[t];
        end
      end
    end
  end

endmodule

// File: rtl/spad_bank_ram.sv
module spad_bank_ram #(
  parameter int DW    = 32,
  parameter int ROW_W = 4,
  localparam int ROWS = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      rdata <= mem[row];
    end
  end

endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
  import spad_pkg::*;
#(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int ROWS  = 16,
  parameter int DW    = 32,
  parameter bit HASH  = 1'b0,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int AW     = BANK_W + ROW_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                rsp_done,
  output logic [LANES*DW-1:0] rsp_rdata
);

  spad_state_e                 state;
  logic                        is_wr;
  logic [LANES-1:0][AW-1:0]    addr_q;
  logic [LANES-1:0][DW-1:0]    wd_q;
  logic [LANES-1:0][DW-1:0]    rdata_q;
  logic [LANES-1:0]            pend;
  logic [LANES-1:0]            served;
  logic [LANES-1:0]            served_q;
  logic [LANES-1:0]            sched_pend;
  logic                        done_q;
  logic                        serving;

  logic [LANES-1:0][BANK_W-1:0] lane_bank;
  logic [LANES-1:0][ROW_W-1:0]  lane_row;
  logic [BANKS-1:0]             bank_en;
  logic [BANKS-1:0][ROW_W-1:0]  bank_row;
  logic [BANKS-1:0][DW-1:0]     bank_wd;
  logic [BANKS-1:0][DW-1:0]     bank_dout;

  assign serving    = (state == ST_SERVE);
  assign sched_pend = serving ? pend : '0;
  assign req_ready  = (state == ST_IDLE);
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;

  spad_bank_map #(
    .LANES(LANES), .BANK_W(BANK_W), .ROW_W(ROW_W), .HASH(HASH)
  ) u_map (
    .addr (addr_q),
    .bank (lane_bank),
    .row  (lane_row)
  );

  spad_sched #(
    .LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .DW(DW)
  ) u_sched (
    .pend      (sched_pend),
    .lane_bank (lane_bank),
    .lane_row  (lane_row),
    .lane_wd   (wd_q),
    .served    (served),
    .bank_en   (bank_en),
    .bank_row  (bank_row),
    .bank_wd   (bank_wd)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    spad_bank_ram #(.DW(DW), .ROW_W(ROW_W)) u_ram (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (is_wr),
      .row   (bank_row[b]),
      .wdata (bank_wd[b]),
      .rdata (bank_dout[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      is_wr    <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      rdata_q  <= '0;
      pend     <= '0;
      served_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      // Bank reads land one edge after issue; gather them per lane.
      for (int t = 0; t < LANES; t++) begin
        if (served_q[t] && !is_wr) rdata_q[t] <= bank_dout[lane_bank[t]];
      end
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            is_wr    <= req_write;
            addr_q   <= req_addr;
            wd_q     <= req_wdata;
            rdata_q  <= '0;
            served_q <= '0;
            pend     <= req_mask;
            state    <= (req_mask == '0) ? ST_LAST : ST_SERVE;
          end
        end
        ST_SERVE: begin
          pend     <= pend & ~served;
          served_q <= served;
          if ((pend & ~served) == '0) state <= ST_LAST;
        end
        ST_LAST: begin
          served_q <= '0;
          done_q   <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spad_checker.sv
module spad_checker #(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_done,
  input logic             serving,
  input logic [LANES-1:0] pend,
  input logic [LANES-1:0] served
);

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r7_no_new_lanes: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> ((pend & ~$past(pend)) == '0));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(!req_ready));

  a_r1_served_pending: assert property (@(posedge clk) disable iff (rst)
    (served & ~pend) == '0);

  a_r3_progress: assert property (@(posedge clk) disable iff (rst)
    (serving && pend != '0) |-> served != '0);

endmodule

bind banked_scratchpad spad_checker #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .serving   (serving),
  .pend      (pend),
  .served    (served)
);

// File: tb/banked_scratchpad_tb.sv
module banked_scratchpad_tb;

  localparam int LANES = 32;
  localparam int DW    = 32;
  localparam int AW    = 9;
  localparam int WORDS = 512;
  localparam int NV    = 9;
  // kind (0 stride, 1 bank permutation, 2 broadcast), step, base, K plain, K folded (0 = unchecked)
  localparam int VECS [NV][5] = '{
    '{0,  1,   0,  1, 1},
    '{0,  3,   0,  1, 0},
    '{1,  7,   3,  1, 1},
    '{2,  0,  77,  1, 1},
    '{0,  2,   0,  2, 1},
    '{0,  4,   0,  4, 1},
    '{0,  8,   0,  8, 1},
    '{0, 16,   0, 16, 1},
    '{0,  1, 100,  1, 2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_m = 1'b0, valid_h = 1'b0;
  logic req_write = 1'b0;
  logic [LANES-1:0] req_mask = '0;
  logic [LANES-1:0][AW-1:0] b_addr = '0;
  logic [LANES-1:0][DW-1:0] b_wd = '0;
  logic ready_m, ready_h, done_m, done_h;
  logic [LANES-1:0][DW-1:0] rd_m, rd_h;

  logic [DW-1:0] shadow [WORDS];
  int n_chk = 0, n_fail = 0, seq = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  banked_scratchpad #(.HASH(1'b0)) u_dut (
    .clk(clk), .rst(rst), .req_valid(valid_m), .req_ready(ready_m),
    .req_write(req_write), .req_mask(req_mask), .req_addr(b_addr),
    .req_wdata(b_wd), .rsp_done(done_m), .rsp_rdata(rd_m));

  banked_scratchpad #(.HASH(1'b1)) u_dut_hash (
    .clk(clk), .rst(rst), .req_valid(valid_h), .req_ready(ready_h),
    .req_write(req_write), .req_mask(req_mask), .req_addr(b_addr),
    .req_wdata(b_wd), .rsp_done(done_h), .rsp_rdata(rd_h));

  task automatic chk(input string rq, input bit ok, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_data(input string rq, input string what, input bit wr,
                          input logic [LANES-1:0][DW-1:0] got);
    logic [DW-1:0] e;
    int bad;
    bad = -1;
    for (int t = 0; t < LANES; t++) begin
      e = (!wr && req_mask[t]) ? shadow[b_addr[t]] : '0;
      if (got[t] !== e && bad < 0) bad = t;
    end
    if (bad < 0) chk(rq, 1'b1, what, 0, 0);
    else begin
      e = (!wr && req_mask[bad]) ? shadow[b_addr[bad]] : '0;
      chk(rq, 1'b0, $sformatf("%s lane %0d", what, bad), got[bad], e);
    end
  endtask

  task automatic fill(input int kind, input int step, input int base);
    int a;
    seq++;
    for (int t = 0; t < LANES; t++) begin
      case (kind)
        0:       a = base + t * step;
        1:       a = (t * step + base) % 32;
        default: a = base;
      endcase
      b_addr[t] = AW'(a);
      b_wd[t]   = 32'hA500_0000 | ((seq & 255) << 16) | (t << 8) | (a & 255);
    end
  endtask

  task automatic issue(input bit wr, input logic [LANES-1:0] mask, input bit use_h,
                       output int lat_m, output int lat_h);
    while (!(ready_m && (ready_h || !use_h))) @(negedge clk);
    req_write = wr;
    req_mask  = mask;
    valid_m   = 1'b1;
    valid_h   = use_h;
    @(posedge clk);
    @(negedge clk);
    valid_m = 1'b0;
    valid_h = 1'b0;
    lat_m = -1;
    lat_h = use_h ? -1 : 0;
    for (int n = 1; n <= 40; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (done_m && lat_m < 0) lat_m = n;
      if (use_h && done_h && lat_h < 0) lat_h = n;
      if (lat_m >= 0 && lat_h >= 0) break;
    end
    if (wr) for (int t = 0; t < LANES; t++) if (mask[t]) shadow[b_addr[t]] = b_wd[t];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lm, lh;
    bit busy_ok;
    logic [LANES-1:0][DW-1:0] held;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10", ready_m == 1'b1, "ready after reset", ready_m, 1);
    chk("R10", done_m == 1'b0, "done after reset", done_m, 0);
    chk("R10", rd_m == '0, "rdata after reset", rd_m[0], 0);

    // Table walk: write a pattern, then read it back, on both mappings (R1 R2 R3 R4 R5 R9)
    for (int v = 0; v < NV; v++) begin
      fill(VECS[v][0], VECS[v][1], VECS[v][2]);
      issue(1'b1, '1, 1'b1, lm, lh);
      chk("R1", lm == VECS[v][3] + 1, $sformatf("vec %0d write latency", v), lm, VECS[v][3] + 1);
      if (VECS[v][4] != 0)
        chk("R9", lh == VECS[v][4] + 1, $sformatf("vec %0d folded write latency", v), lh, VECS[v][4] + 1);
      chk_data("R5", $sformatf("vec %0d write rdata", v), 1'b1, rd_m);
      issue(1'b0, '1, 1'b1, lm, lh);
      chk(VECS[v][3] > 1 ? "R3" : "R2", lm == VECS[v][3] + 1,
          $sformatf("vec %0d read latency", v), lm, VECS[v][3] + 1);
      if (VECS[v][4] != 0)
        chk("R9", lh == VECS[v][4] + 1, $sformatf("vec %0d folded read latency", v), lh, VECS[v][4] + 1);
      chk_data(VECS[v][0] == 2 ? "R4" : "R5", $sformatf("vec %0d read data", v), 1'b0, rd_m);
      chk_data("R9", $sformatf("vec %0d folded read data", v), 1'b0, rd_h);
    end

    // R8: data held after the done pulse
    held = rd_m;
    repeat (3) @(negedge clk);
    chk("R8", done_m == 1'b0, "done drops after pulse", done_m, 0);
    chk("R8", rd_m == held, "rdata held after done", rd_m[0], held[0]);

    // R11: empty mask
    fill(0, 1, 0);
    issue(1'b0, '0, 1'b1, lm, lh);
    chk("R11", lm == 1, "empty mask latency", lm, 1);
    chk("R11", rd_m == '0, "empty mask rdata", rd_m[0], 0);

    // R5: partial write leaves inactive lanes' words alone; partial read zeroes them
    fill(0, 1, 200);
    issue(1'b1, '1, 1'b1, lm, lh);
    fill(0, 1, 200);
    issue(1'b1, 32'h5555_5555, 1'b1, lm, lh);
    issue(1'b0, '1, 1'b1, lm, lh);
    chk_data("R5", "after partial write", 1'b0, rd_m);
    issue(1'b0, 32'h0F0F_00FF, 1'b1, lm, lh);
    chk_data("R5", "partial read", 1'b0, rd_m);
    chk("R5", rd_m[8] == '0, "inactive lane 8 reads zero", rd_m[8], 0);

    // R6: shared-address write, highest active lane wins
    fill(2, 0, 300);
    issue(1'b1, 32'h001F_FFF8, 1'b1, lm, lh);
    chk("R4", lm == 2, "shared-address write latency", lm, 2);
    held = b_wd;
    issue(1'b0, '1, 1'b1, lm, lh);
    chk("R6", rd_m[0] == held[20], "highest lane word stored", rd_m[0], held[20]);
    chk("R6", rd_h[31] == held[20], "highest lane word stored folded", rd_h[31], held[20]);

    // R7: valid while busy is ignored
    fill(0, 16, 0);
    while (!ready_m) @(negedge clk);
    req_write = 1'b0;
    req_mask  = '1;
    valid_m   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    held = '0;
    for (int t = 0; t < LANES; t++) held[t] = shadow[t * 16];
    req_write = 1'b1;
    for (int t = 0; t < LANES; t++) begin
      b_addr[t] = AW'(1);
      b_wd[t]   = 32'hDEAD_0000 | t;
    end
    busy_ok = 1'b1;
    lm = -1;
    for (int n = 1; n <= 40; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n <= 10 && ready_m) busy_ok = 1'b0;
      if (n == 10) valid_m = 1'b0;
      if (done_m && lm < 0) begin
        lm = n;
        break;
      end
      if (!done_m && ready_m) busy_ok = 1'b0;
    end
    chk("R7", busy_ok, "ready low while busy", busy_ok, 1);
    chk("R3", lm == 17, "stride 16 latency with held valid", lm, 17);
    chk("R7", rd_m == held, "result unaffected by request during busy", rd_m[1], held[1]);
    fill(2, 0, 1);
    issue(1'b0, '1, 1'b0, lm, lh);
    chk("R7", rd_m[5] == shadow[1], "word 1 not overwritten", rd_m[5], shadow[1]);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule